// File: doc/BRIEF.md
# Pairwise Von Neumann Bias Remover

This block takes a serial stream of raw random bits and produces unbiased bits using the von Neumann pair method. Each raw bit goes into a two-bit pair register. The pair is judged once every two cycles, so no bit belongs to two pairs. A pair with unequal bits yields one output bit and a valid strobe that lasts one cycle. A pair with equal bits is discarded.

The block stays idle while `start` is low. In a full generator, `start` is the flag raised when the oscillator enable chain has completely filled. Lowering `start` clears the pair register and the phase. Each run therefore begins with a pair made of two newly sampled bits.

Top module: `vn_debias`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `bit_vld` and `bit_out` are 0.
- R2: Every cycle in which `start` was low at the previous rising edge shows `bit_vld` = 0, whatever the value of `raw_bit`.
- R3: A pair whose first sampled bit is 0 and second is 1 raises `bit_vld` with `bit_out` = 1.
- R4: A pair whose first sampled bit is 1 and second is 0 raises `bit_vld` with `bit_out` = 0.
- R5: A pair of two equal bits (00 or 11) leaves `bit_vld` low.
- R6: Pairs do not overlap. Counting from the first edge at which `start` is high, bits 0 and 1 form the first pair, bits 2 and 3 the next, and so on. The result of a pair appears in the cycle after the edge that captures its second bit.
- R7: `bit_vld` lasts exactly one cycle, and at least two cycles separate consecutive strobes.
- R8: When `start` drops and rises again, the pairing restarts. A bit captured before the drop never enters a pair after the restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Run enable; high once the entropy enable chain has completed |
| raw_bit | input | 1 | Raw bit sampled from the entropy source |
| bit_out | output | 1 | Unbiased output bit, meaningful while `bit_vld` is high |
| bit_vld | output | 1 | One-cycle strobe marking a new output bit |

## Verification
The assertions assume that `raw_bit` and `start` are synchronous to `clk` and settle well before each rising edge. They also assume that reset is released only while `start` is low, so that the first pair after reset is counted from a known edge. The stimulus meets these assumptions by changing every input on the falling edge and keeping `start` low across reset. It covers all 256 eight-bit raw sequences, each preceded by two cycles with `start` low. It also drops `start` halfway through a pair, so the restart behaviour is exercised with a stale bit left in the register.

// File: rtl/vn_debias_pkg.sv
package vn_debias_pkg;

    localparam int unsigned PAIR_W = 2;

    typedef struct packed {
        logic [PAIR_W-1:0] pair;
        logic              phase;
    } vn_track_t;

    typedef struct packed {
        logic bit_v;
        logic vld;
    } vn_out_t;

endpackage

// File: rtl/vn_pair_track.sv
module vn_pair_track
    import vn_debias_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic raw_bit,
    output logic phase,
    output logic held
);

    vn_track_t st_d;
    vn_track_t st_q;

    always_comb begin
        st_d = st_q;
        if (!start) begin
            st_d.pair  = '0;
            st_d.phase = 1'b0;
        end else begin
            st_d.pair  = {st_q.pair[PAIR_W-2:0], raw_bit};
            st_d.phase = ~st_q.phase;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // phase=1: the bit arriving now closes a pair with the held bit
    assign phase = st_q.phase;
    assign held  = st_q.pair[0];

endmodule

// File: rtl/vn_judge.sv
module vn_judge (
    input  logic start,
    input  logic phase,
    input  logic held,
    input  logic raw_bit,
    output logic emit,
    output logic value
);

    always_comb begin
        emit  = 1'b0;
        value = 1'b0;
        if (start && phase) begin
            // unequal pair: 01 gives 1, 10 gives 0, i.e. the second bit
            emit  = held ^ raw_bit;
            value = raw_bit;
        end
    end

endmodule

// File: rtl/vn_out_reg.sv
module vn_out_reg
    import vn_debias_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic emit,
    input  logic value,
    output logic bit_out,
    output logic bit_vld
);

    vn_out_t o_d;
    vn_out_t o_q;

    always_comb begin
        o_d     = o_q;
        o_d.vld = emit;
        if (emit) begin
            o_d.bit_v = value;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign bit_out = o_q.bit_v;
    assign bit_vld = o_q.vld;

endmodule

// File: rtl/vn_debias.sv
module vn_debias (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic raw_bit,
    output logic bit_out,
    output logic bit_vld
);

    logic phase;
    logic held;
    logic emit;
    logic value;

    vn_pair_track i_track (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .raw_bit (raw_bit),
        .phase   (phase),
        .held    (held)
    );

    vn_judge i_judge (
        .start   (start),
        .phase   (phase),
        .held    (held),
        .raw_bit (raw_bit),
        .emit    (emit),
        .value   (value)
    );

    vn_out_reg i_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .emit    (emit),
        .value   (value),
        .bit_out (bit_out),
        .bit_vld (bit_vld)
    );

endmodule

// File: rtl/vn_debias_chk.sv
module vn_debias_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic raw_bit,
    input logic bit_out,
    input logic bit_vld
);

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!bit_vld && !bit_out); // R1
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> !bit_vld); // R2

    AST_EDGE_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> (($past(raw_bit, 2) != $past(raw_bit)) && (bit_out == $past(raw_bit)))); // R3

    AST_TWO_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |-> ($past(start) && $past(start, 2))); // R8

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_vld |=> !bit_vld); // R7

endmodule

bind vn_debias vn_debias_chk i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .raw_bit (raw_bit),
    .bit_out (bit_out),
    .bit_vld (bit_vld)
);

// File: tb/test_vn_debias.sv
module test_vn_debias;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic raw_bit = 1'b0;
    logic bit_out;
    logic bit_vld;

    int unsigned n_checks = 0;
    int unsigned n_errors = 0;
    bit          done = 1'b0;

    // bench model state
    bit m_phase = 1'b0;
    bit m_prev  = 1'b0;
    bit m_last_vld = 1'b0;
    string tag_over = "";

    always #5 clk = ~clk;

    vn_debias i_vn_debias (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .raw_bit (raw_bit),
        .bit_out (bit_out),
        .bit_vld (bit_vld)
    );

    task automatic check(input string req, input logic act, input logic exp, input string what);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    // drive at negedge, let one rising edge pass, check at next negedge
    task automatic step(input bit st, input bit b);
        bit    exp_vld;
        string req;
        start   = st;
        raw_bit = b;
        @(posedge clk);
        @(negedge clk);
        exp_vld = 1'b0;
        if (!st) begin
            req = "R2";
            m_phase = 1'b0;
            m_prev  = 1'b0;
        end else begin
            if (m_phase) begin
                exp_vld = (m_prev != b);
                req = exp_vld ? (b ? "R3" : "R4") : "R5";
            end else begin
                req = m_last_vld ? "R7" : "R6";
            end
            m_phase = ~m_phase;
            m_prev  = b;
        end
        if (tag_over != "") req = tag_over;
        check(req, bit_vld, exp_vld, "bit_vld");
        if (exp_vld) check(req, bit_out, b, "bit_out");
        m_last_vld = exp_vld;
    endtask

    initial begin
        @(negedge clk);
        check("R1", bit_vld, 1'b0, "bit_vld in reset");
        check("R1", bit_out, 1'b0, "bit_out in reset");
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", bit_vld, 1'b0, "bit_vld after reset");
        check("R1", bit_out, 1'b0, "bit_out after reset");

        // R2: idle with toggling raw input
        for (int i = 0; i < 20; i++) step(1'b0, i[0]);

        // exhaustive sweep of 4 pairs (R3 R4 R5 R6 R7)
        for (int s = 0; s < 256; s++) begin
            step(1'b0, 1'b1);
            step(1'b0, 1'b0);
            for (int k = 7; k >= 0; k--) step(1'b1, s[k]);
        end

        // R8: drop start mid-pair with a 1 held, restart with 0,0 -> no strobe
        tag_over = "R8";
        step(1'b0, 1'b0);
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        // restart again, fresh pair 0,1 -> strobe with 1
        step(1'b1, 1'b1);
        step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        tag_over = "";

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule